// File: doc/BRIEF.md
# Subpixel Vertical-Edge Locator

The block takes a raster stream of greyscale pixels, one pixel per cycle when `pix_valid` is high. It keeps the two previous rows in on-chip line buffers and slides a 3x3 window across the image. From that window it forms the magnitude of the horizontal-derivative Sobel response, which is strong wherever brightness changes along a row. It then scans each row of gradient magnitudes for local maxima that exceed a programmable threshold.

Each maximum is refined to a fraction of a pixel. A parabola is fitted through the peak and its two horizontal neighbours, and its vertex offset is found by a bit-serial divider. Peaks wait in a small queue while the divider is busy. Results leave as one-cycle records holding the row, the integer column and a signed Q1.7 offset. A stereo matcher downstream can use these records directly.

The divider is a three-state machine:
- **IDLE** waits for a queued peak. The transition *take* (queue not empty) pops the peak, loads the operands and goes to **RUN**.
- **RUN** retires one quotient bit per cycle. The transition *done* (last bit) goes to **EMIT**.
- **EMIT** drives the record for one cycle. The transition *release* returns to **IDLE**.

Top module: `subpix_edge_locator`

## Requirements
- R1: A cycle with `frame_start` and `pix_valid` both high places that pixel at row 0, column 0. Each further accepted pixel advances the column. After column IMG_W-1 the column returns to 0 and the row increments. Cycles with `pix_valid` low do not advance the position.
- R2: The gradient at (r,c) is |S(c+1) - S(c-1)|, where S(x) = p(r-1,x) + 2·p(r,x) + p(r+1,x).
- R3: Column c is an edge when three conditions hold: its gradient g0 is greater than or equal to `edge_thresh`, g0 is strictly greater than the left gradient g-, and g0 is greater than or equal to the right gradient g+. Two adjacent columns are therefore never both edges.
- R4: Edges are reported only for rows 1 to IMG_H-2 and for columns 2 to IMG_W-3.
- R5: `edge_frac` is the 8-bit two's-complement value trunc(128·(g+ - g-) / (2·(2·g0 - g- - g+))), with truncation toward zero. A positive value means the edge lies to the right of `edge_col`, and 64 means half a pixel.
- R6: The magnitude of `edge_frac` never exceeds 64.
- R7: Each edge gives one record, and `edge_valid` is high for exactly one cycle per record. Records leave in raster order, with `edge_row` and `edge_col` giving the peak position.
- R8: With the divider idle and the queue empty, the record for a peak at (r,c) appears 10 clock edges after the edge that accepts the pixel at (r+1, c+2).
- R9: A `frame_start` in the middle of a frame restarts the row and column count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Marks the first pixel of a frame (qualified by pix_valid) |
| pix_valid | input | 1 | Pixel strobe |
| pix_data | input | PIX_W | Pixel intensity |
| edge_thresh | input | PIX_W+2 | Minimum gradient for an edge |
| edge_valid | output | 1 | One-cycle record strobe |
| edge_row | output | $clog2(IMG_H) | Row of the edge |
| edge_col | output | $clog2(IMG_W) | Integer column of the edge |
| edge_frac | output | 8 | Signed Q1.7 subpixel offset |

## Verification
The pixel path has fixed stages: window, gradient, queue push, operand load, seven divide steps and emit. A record is therefore due exactly 10 edges after the pixel that completes the right-hand neighbour of its peak. The bench records the cycle at which that pixel is accepted and compares it with the cycle of the first record in each frame. All outputs are sampled on the falling clock edge. Row, column and offset of every record are compared only after each frame has drained, so queueing delay for later records cannot skew their contents.

// File: rtl/edge_pkg.sv
package edge_pkg;
    typedef enum logic [1:0] {
        DIV_IDLE = 2'd0,
        DIV_RUN  = 2'd1,
        DIV_EMIT = 2'd2
    } div_state_e;
endpackage

// File: rtl/sobel_window.sv
module sobel_window #(
    parameter int IMG_W = 512,
    parameter int IMG_H = 80,
    parameter int PIX_W = 8,
    localparam int COL_W  = $clog2(IMG_W),
    localparam int ROW_W  = $clog2(IMG_H),
    localparam int GRAD_W = PIX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              pix_valid,
    input  logic [PIX_W-1:0]  pix_data,
    output logic              grad_valid,
    output logic [GRAD_W-1:0] grad_mag,
    output logic [ROW_W-1:0]  grad_row,
    output logic [COL_W-1:0]  grad_col
);
    logic [PIX_W-1:0] line_a [0:IMG_W-1];
    logic [PIX_W-1:0] line_b [0:IMG_W-1];
    logic [PIX_W-1:0] tap_top [0:2];
    logic [PIX_W-1:0] tap_mid [0:2];
    logic [PIX_W-1:0] tap_bot [0:2];

    logic [COL_W-1:0] col_q, cur_col, win_col;
    logic [ROW_W-1:0] row_q, cur_row, win_row;
    logic             win_new;

    assign cur_col = frame_start ? '0 : col_q;
    assign cur_row = frame_start ? '0 : row_q;

    // raster position (R1, R9)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '0;
            row_q <= '0;
        end else if (pix_valid) begin
            if (cur_col == COL_W'(IMG_W - 1)) begin
                col_q <= '0;
                row_q <= (cur_row == ROW_W'(IMG_H - 1)) ? '0 : cur_row + ROW_W'(1);
            end else begin
                col_q <= cur_col + COL_W'(1);
                row_q <= cur_row;
            end
        end
    end

    // line buffers and window taps
    always_ff @(posedge clk) begin
        if (pix_valid) begin
            line_a[cur_col] <= pix_data;
            line_b[cur_col] <= line_a[cur_col];
            tap_top[0] <= line_b[cur_col];
            tap_mid[0] <= line_a[cur_col];
            tap_bot[0] <= pix_data;
            for (int i = 1; i < 3; i++) begin
                tap_top[i] <= tap_top[i-1];
                tap_mid[i] <= tap_mid[i-1];
                tap_bot[i] <= tap_bot[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_new <= 1'b0;
            win_col <= '0;
            win_row <= '0;
        end else begin
            win_new <= pix_valid;
            if (pix_valid) begin
                win_col <= cur_col;
                win_row <= cur_row;
            end
        end
    end

    // Sobel-x magnitude (R2)
    logic [GRAD_W-1:0]       sum_right, sum_left;
    logic signed [GRAD_W:0]  diff;
    logic [GRAD_W-1:0]       mag_c;

    always_comb begin
        sum_right = GRAD_W'(tap_top[0]) + (GRAD_W'(tap_mid[0]) << 1) + GRAD_W'(tap_bot[0]);
        sum_left  = GRAD_W'(tap_top[2]) + (GRAD_W'(tap_mid[2]) << 1) + GRAD_W'(tap_bot[2]);
        diff      = $signed({1'b0, sum_right}) - $signed({1'b0, sum_left});
        mag_c     = diff[GRAD_W] ? GRAD_W'(-diff) : diff[GRAD_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grad_valid <= 1'b0;
            grad_mag   <= '0;
            grad_row   <= '0;
            grad_col   <= '0;
        end else begin
            grad_valid <= win_new && (win_col >= COL_W'(2)) && (win_row >= ROW_W'(2));
            if (win_new) begin
                grad_mag <= mag_c;
                grad_col <= win_col - COL_W'(1);
                grad_row <= win_row - ROW_W'(1);
            end
        end
    end

    assert_grad_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        grad_valid |-> (grad_col >= COL_W'(1)) && (grad_col <= COL_W'(IMG_W - 2)) &&
                       (grad_row >= ROW_W'(1)) && (grad_row <= ROW_W'(IMG_H - 2)));
endmodule

// File: rtl/peak_picker.sv
module peak_picker #(
    parameter int COL_W  = 9,
    parameter int ROW_W  = 7,
    parameter int GRAD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grad_valid,
    input  logic [GRAD_W-1:0] grad_mag,
    input  logic [ROW_W-1:0]  grad_row,
    input  logic [COL_W-1:0]  grad_col,
    input  logic [GRAD_W-1:0] thresh,
    output logic              push,
    output logic [ROW_W-1:0]  push_row,
    output logic [COL_W-1:0]  push_col,
    output logic [GRAD_W-1:0] push_gl,
    output logic [GRAD_W-1:0] push_gc,
    output logic [GRAD_W-1:0] push_gr
);
    logic [GRAD_W-1:0] hist_l, hist_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_l <= '0;
            hist_c <= '0;
        end else if (grad_valid) begin
            hist_l <= hist_c;
            hist_c <= grad_mag;
        end
    end

    // candidate is the column left of the newest gradient (R3, R4)
    always_comb begin
        push     = grad_valid && (grad_col >= COL_W'(3)) && (hist_c >= thresh) &&
                   (hist_c > hist_l) && (hist_c >= grad_mag);
        push_row = grad_row;
        push_col = grad_col - COL_W'(1);
        push_gl  = hist_l;
        push_gc  = hist_c;
        push_gr  = grad_mag;
    end

    assert_no_adjacent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push);
endmodule

// File: rtl/peak_fifo.sv
module peak_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 48,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          empty
);
    logic [DW-1:0] mem [0:DEPTH-1];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          full, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        empty |=> (count <= CW'(1)));
endmodule

// File: rtl/frac_divider.sv
module frac_divider
    import edge_pkg::*;
#(
    parameter int COL_W  = 9,
    parameter int ROW_W  = 7,
    parameter int GRAD_W = 10,
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_empty,
    input  logic [ROW_W-1:0]  q_row,
    input  logic [COL_W-1:0]  q_col,
    input  logic [GRAD_W-1:0] q_gl,
    input  logic [GRAD_W-1:0] q_gc,
    input  logic [GRAD_W-1:0] q_gr,
    output logic              q_pop,
    output logic              edge_valid,
    output logic [ROW_W-1:0]  edge_row,
    output logic [COL_W-1:0]  edge_col,
    output logic [FRAC_W-1:0] edge_frac
);
    localparam int ITER  = FRAC_W - 1;
    localparam int CNT_W = $clog2(ITER + 1);
    localparam int DEN_W = GRAD_W + 2;
    localparam int REM_W = DEN_W + 1;
    localparam logic [FRAC_W-1:0] HALF = FRAC_W'(1) << (FRAC_W - 2);

    div_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [REM_W-1:0]  rem_q, rem_sh;
    logic [DEN_W-1:0]  den_q, half_den, den_c;
    logic [FRAC_W-1:0] quo_q, qmag;
    logic              neg_q, ge;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;

    // operands (R5): numerator magnitude and positive denominator
    always_comb begin
        half_den = (DEN_W'(q_gc) << 1) - DEN_W'(q_gl) - DEN_W'(q_gr);
        den_c    = half_den << 1;
        rem_sh   = rem_q << 1;
        ge       = (rem_sh >= REM_W'(den_q));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DIV_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DIV_IDLE: if (!q_empty) state_d = DIV_RUN;
            DIV_RUN:  if (cnt_q == CNT_W'(ITER - 1)) state_d = DIV_EMIT;
            DIV_EMIT: state_d = DIV_IDLE;
            default:  state_d = DIV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rem_q <= '0;
            den_q <= '0;
            quo_q <= '0;
            neg_q <= 1'b0;
            row_q <= '0;
            col_q <= '0;
        end else begin
            unique case (state_q)
                DIV_IDLE: if (!q_empty) begin
                    cnt_q <= '0;
                    quo_q <= '0;
                    den_q <= den_c;
                    neg_q <= (q_gr < q_gl);
                    rem_q <= (q_gr < q_gl) ? REM_W'(q_gl - q_gr) : REM_W'(q_gr - q_gl);
                    row_q <= q_row;
                    col_q <= q_col;
                end
                DIV_RUN: begin
                    rem_q <= ge ? rem_sh - REM_W'(den_q) : rem_sh;
                    quo_q <= {quo_q[FRAC_W-2:0], ge};
                    cnt_q <= cnt_q + CNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    // outputs (R6, R7)
    always_comb begin
        q_pop      = (state_q == DIV_IDLE) && !q_empty;
        edge_valid = (state_q == DIV_EMIT);
        edge_row   = row_q;
        edge_col   = col_q;
        qmag       = (quo_q > HALF) ? HALF : quo_q;
        edge_frac  = neg_q ? FRAC_W'(-qmag) : qmag;
    end

    assert_rem_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DIV_RUN) |-> (rem_q < REM_W'(den_q)));
    assert_frac_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        edge_valid |-> ($signed(edge_frac) <= $signed(HALF)) &&
                       ($signed(edge_frac) >= -$signed(HALF)));
    assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        edge_valid |=> !edge_valid);
    assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop |=> (state_q == DIV_RUN) && (cnt_q == '0));
endmodule

// File: rtl/subpix_edge_locator.sv
module subpix_edge_locator #(
    parameter int IMG_W      = 512,
    parameter int IMG_H      = 80,
    parameter int PIX_W      = 8,
    parameter int FIFO_DEPTH = 4,
    localparam int COL_W  = $clog2(IMG_W),
    localparam int ROW_W  = $clog2(IMG_H),
    localparam int GRAD_W = PIX_W + 2,
    localparam int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              pix_valid,
    input  logic [PIX_W-1:0]  pix_data,
    input  logic [GRAD_W-1:0] edge_thresh,
    output logic              edge_valid,
    output logic [ROW_W-1:0]  edge_row,
    output logic [COL_W-1:0]  edge_col,
    output logic [FRAC_W-1:0] edge_frac
);
    localparam int REC_W = ROW_W + COL_W + 3 * GRAD_W;

    logic              g_valid;
    logic [GRAD_W-1:0] g_mag;
    logic [ROW_W-1:0]  g_row;
    logic [COL_W-1:0]  g_col;

    logic              p_push;
    logic [ROW_W-1:0]  p_row;
    logic [COL_W-1:0]  p_col;
    logic [GRAD_W-1:0] p_gl, p_gc, p_gr;

    logic [REC_W-1:0]  f_din, f_dout;
    logic              f_empty, f_pop;

    sobel_window #(.IMG_W(IMG_W), .IMG_H(IMG_H), .PIX_W(PIX_W)) u_window (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_valid(pix_valid),
        .pix_data(pix_data), .grad_valid(g_valid), .grad_mag(g_mag),
        .grad_row(g_row), .grad_col(g_col)
    );

    peak_picker #(.COL_W(COL_W), .ROW_W(ROW_W), .GRAD_W(GRAD_W)) u_peaks (
        .clk(clk), .rst_n(rst_n), .grad_valid(g_valid), .grad_mag(g_mag),
        .grad_row(g_row), .grad_col(g_col), .thresh(edge_thresh),
        .push(p_push), .push_row(p_row), .push_col(p_col),
        .push_gl(p_gl), .push_gc(p_gc), .push_gr(p_gr)
    );

    assign f_din = {p_row, p_col, p_gl, p_gc, p_gr};

    peak_fifo #(.DEPTH(FIFO_DEPTH), .DW(REC_W)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(p_push), .din(f_din),
        .pop(f_pop), .dout(f_dout), .empty(f_empty)
    );

    frac_divider #(.COL_W(COL_W), .ROW_W(ROW_W), .GRAD_W(GRAD_W), .FRAC_W(FRAC_W)) u_div (
        .clk(clk), .rst_n(rst_n), .q_empty(f_empty),
        .q_row(f_dout[REC_W-1 -: ROW_W]),
        .q_col(f_dout[3*GRAD_W +: COL_W]),
        .q_gl(f_dout[2*GRAD_W +: GRAD_W]),
        .q_gc(f_dout[GRAD_W +: GRAD_W]),
        .q_gr(f_dout[0 +: GRAD_W]),
        .q_pop(f_pop), .edge_valid(edge_valid), .edge_row(edge_row),
        .edge_col(edge_col), .edge_frac(edge_frac)
    );
endmodule

// File: tb/subpix_edge_locator_tb_top.sv
`timescale 1ns/1ps
module subpix_edge_locator_tb_top;
    localparam int W = 16;
    localparam int H = 8;

    typedef struct packed {
        int s; int v1; int v2; int thr; int gap; int n; int frac;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{6,  0, 50,  10, 0, 6,  64},
        '{5, 10, 40,  10, 0, 6,  32},
        '{8, 30, 40,  10, 0, 6, -32},
        '{7, 20, 40,  10, 0, 6,   0},
        '{4,  5, 30,  10, 1, 6,  42},
        '{9, 25, 30,  10, 2, 6, -42},
        '{6,  0, 50, 201, 0, 0,   0},
        '{6,  0, 50, 200, 0, 6,  64},
        '{2,  0, 60,  10, 0, 6,  64},
        '{1,  0, 60,  10, 0, 0,   0},
        '{13, 0, 60,  10, 0, 6,  64},
        '{14, 0, 60,  10, 1, 0,   0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic       pix_valid = 1'b0;
    logic [7:0] pix_data = '0;
    logic [9:0] edge_thresh = '0;
    logic       edge_valid;
    logic [2:0] edge_row;
    logic [3:0] edge_col;
    logic [7:0] edge_frac;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int trig_cyc = 0;
    int rec_n = 0;
    int rec_row [0:31];
    int rec_col [0:31];
    int rec_frac [0:31];
    int rec_cyc [0:31];

    subpix_edge_locator #(.IMG_W(W), .IMG_H(H)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_valid(pix_valid),
        .pix_data(pix_data), .edge_thresh(edge_thresh), .edge_valid(edge_valid),
        .edge_row(edge_row), .edge_col(edge_col), .edge_frac(edge_frac)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && edge_valid && rec_n < 32) begin
            rec_row[rec_n]  = int'(edge_row);
            rec_col[rec_n]  = int'(edge_col);
            rec_frac[rec_n] = int'($signed(edge_frac));
            rec_cyc[rec_n]  = cyc;
            rec_n = rec_n + 1;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic int pix_val(input int x, input int s, input int v1, input int v2);
        if (x < s) return 0;
        if (x == s) return v1;
        return v2;
    endfunction

    task automatic drive_frame(input int s, input int v1, input int v2, input int gap,
                               input int rows, input bit sof);
        for (int r = 0; r < rows; r++) begin
            for (int x = 0; x < W; x++) begin
                if (gap > 0 && (x % 4) == 1) begin
                    repeat (gap) begin
                        @(negedge clk);
                        pix_valid = 1'b0;
                        frame_start = 1'b0;
                    end
                end
                @(negedge clk);
                pix_valid = 1'b1;
                pix_data = 8'(pix_val(x, s, v1, v2));
                frame_start = sof && (r == 0) && (x == 0);
                if (r == 2 && x == s + 2) trig_cyc = cyc + 1;
            end
        end
        @(negedge clk);
        pix_valid = 1'b0;
        frame_start = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R8 watchdog act=timeout exp=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // reset state
        repeat (3) @(negedge clk);
        check("R7 edge_valid in reset", int'(edge_valid), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 edge_valid after reset", int'(edge_valid), 0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            edge_thresh = 10'(VECS[v].thr);
            rec_n = 0;
            drive_frame(VECS[v].s, VECS[v].v1, VECS[v].v2, VECS[v].gap, H, 1'b1);
            repeat (80) @(negedge clk);
            check($sformatf("R1/R3/R4 count vec%0d", v), rec_n, VECS[v].n);
            for (int k = 0; k < rec_n && k < VECS[v].n; k++) begin
                check($sformatf("R7 row vec%0d rec%0d", v, k), rec_row[k], k + 1);
                check($sformatf("R4 col vec%0d rec%0d", v, k), rec_col[k], VECS[v].s);
                check($sformatf("R2/R5/R6 frac vec%0d rec%0d", v, k), rec_frac[k], VECS[v].frac);
            end
            if (VECS[v].n > 0 && rec_n > 0)
                check($sformatf("R8 latency vec%0d", v), rec_cyc[0] - trig_cyc, 10);
        end

        // R9: restart in the middle of a frame
        edge_thresh = 10'd10;
        rec_n = 0;
        drive_frame(6, 0, 50, 0, 3, 1'b1);
        drive_frame(6, 0, 50, 0, H, 1'b1);
        repeat (80) @(negedge clk);
        check("R9 restart count", rec_n, 7);
        check("R9 partial frame row", rec_row[0], 1);
        for (int k = 1; k < rec_n && k < 7; k++)
            check($sformatf("R9 restarted row rec%0d", k), rec_row[k], k);

        // R1: frame continues without frame_start (rows wrap)
        rec_n = 0;
        drive_frame(6, 0, 50, 0, H, 1'b0);
        repeat (80) @(negedge clk);
        check("R1 wrap count", rec_n, 6);
        if (rec_n > 0) check("R1 wrap first row", rec_row[0], 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule